// File: doc/BRIEF.md
# SRAM Sleep Mode Controller

This block sits between a system and a synchronous SRAM core and turns an asynchronous, active-high sleep request into a sequence of safe power states. When a request arrives it is synchronised and an entry guard window opens. At the end of that window the core is forced deselected, its internal clock enable is dropped and its data outputs are forced undriven. Output enable has no say in this. The array contents are never touched, so the stored data survives the sleep.

Leaving sleep is lazy. Removing the request does not wake the core. The block waits in low power until a real command strobe arrives. That strobe starts a recovery window of a parameterised number of cycles, and normal traffic is accepted only once the window has ended. Any strobe or write asserted inside the entry or recovery window is suppressed, because the core stays deselected. It also raises a sticky violation flag that only reset clears.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset the outputs read force_desel=0, core_clk_en=1, out_disable=0, low_power=0 and violation=0.
- R2: sleep_req passes through a two-stage synchroniser. The entry guard window starts on the third rising edge after the request is set up and lasts ENTRY_CYCLES (default 2) cycles. During the window force_desel=1, core_clk_en=1, out_disable=0 and low_power=0.
- R3: At the end of the entry window the block enters low power: low_power=1, core_clk_en=0, out_disable=1 and force_desel=1.
- R4: While in low power, strobes and write signals neither wake the block nor set the violation flag. All outputs keep their low-power values.
- R5: Once the request is removed, the block stays in low power with no end time until a command strobe arrives. Write signals without a strobe do not count as a wake-up.
- R6: A strobe seen in low power with the synchronised request low opens the recovery window on the next edge. From that edge low_power=0, core_clk_en=1 and out_disable=0. force_desel stays 1 for RECOVER_CYCLES (default 2) cycles and then returns to 0.
- R7: A strobe or write assertion seen on an edge inside the entry or recovery window sets violation from that edge on. force_desel stays 1 during the window, so the command is suppressed. Commands in normal operation never set violation.
- R8: A write assertion is defined as one of two cases: wr_global is high, or wr_enable is high together with at least one bit of wr_lanes. wr_enable with all lane bits low is not a write.
- R9: violation stays set until reset and is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| cmd_strobe | input | STROBES | Active-high command start strobes (any bit starts a command) |
| wr_global | input | 1 | Active-high write of all lanes |
| wr_enable | input | 1 | Active-high write qualified by wr_lanes |
| wr_lanes | input | LANES | Per-byte-lane write selects |
| force_desel | output | 1 | Forces the core deselected |
| core_clk_en | output | 1 | Clock enable for the core |
| out_disable | output | 1 | Forces the core data outputs undriven |
| low_power | output | 1 | Block is in the low-power state |
| violation | output | 1 | Sticky flag for a command inside a guard window |

## Verification
The assertions assume three things about the inputs. First, sleep_req is held at each level long enough to pass the synchroniser. Second, the command inputs are synchronous to clk. Third, a wake-up strobe is treated as a single-cycle request. The stimulus keeps to these rules: it changes every input on the falling edge and holds sleep_req steady for at least three edges on each change. It also injects commands one cycle at a time into each guard window and into the low-power state.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;

   typedef enum logic [2:0] {
      SLP_RUN      = 3'd0,
      SLP_ENTER    = 3'd1,
      SLP_ASLEEP   = 3'd2,
      SLP_DROWSY   = 3'd3,
      SLP_RECOVER  = 3'd4
   } slp_state_t;

   function automatic int unsigned slp_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_sleep_sync.sv
module sram_sleep_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sram_sleep_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/sram_sleep_cmd_dec.sv
module sram_sleep_cmd_dec #(
   parameter int unsigned STROBES = 2,
   parameter int unsigned LANES   = 4
) (
   input  logic [STROBES-1:0] cmd_strobe,
   input  logic               wr_global,
   input  logic               wr_enable,
   input  logic [LANES-1:0]   wr_lanes,
   output logic               start_o,
   output logic               write_o
);

   logic [LANES-1:0] lane_hit;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_hit[i] = wr_enable & wr_lanes[i];
      end
   endgenerate

   assign start_o = |cmd_strobe;
   assign write_o = wr_global | (|lane_hit);

endmodule

// File: rtl/sram_sleep_fsm.sv
module sram_sleep_fsm
   import sram_sleep_pkg::*;
#(
   parameter int unsigned ENTRY_CYCLES   = 2,
   parameter int unsigned RECOVER_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic start_i,
   output logic force_desel_o,
   output logic clk_en_o,
   output logic out_dis_o,
   output logic low_power_o,
   output logic in_window_o
);

   localparam int unsigned MAXV  = slp_max(ENTRY_CYCLES, RECOVER_CYCLES);
   localparam int unsigned CNT_W = (MAXV < 2) ? 1 : $clog2(MAXV);

   slp_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         SLP_RUN: begin
            if (req_s) begin
               st_d  = SLP_ENTER;
               cnt_d = CNT_W'(ENTRY_CYCLES - 1);
            end
         end
         SLP_ENTER: begin
            if (cnt_q == '0) st_d  = SLP_ASLEEP;
            else             cnt_d = cnt_q - 1'b1;
         end
         SLP_ASLEEP: begin
            if (!req_s) st_d = SLP_DROWSY;
         end
         SLP_DROWSY: begin
            if (req_s) begin
               st_d = SLP_ASLEEP;
            end else if (start_i) begin
               st_d  = SLP_RECOVER;
               cnt_d = CNT_W'(RECOVER_CYCLES - 1);
            end
         end
         SLP_RECOVER: begin
            if (cnt_q == '0) st_d  = SLP_RUN;
            else             cnt_d = cnt_q - 1'b1;
         end
         default: st_d = SLP_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SLP_RUN;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   logic asleep;
   assign asleep        = (st_q == SLP_ASLEEP) || (st_q == SLP_DROWSY);
   assign in_window_o   = (st_q == SLP_ENTER) || (st_q == SLP_RECOVER);
   assign force_desel_o = (st_q != SLP_RUN);
   assign clk_en_o      = !asleep;
   assign out_dis_o     = asleep;
   assign low_power_o   = asleep;

   // R3
   sleep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_power_o |-> (!clk_en_o && out_dis_o && force_desel_o));

   // R2
   entry_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_RUN && req_s) |=> (in_window_o && force_desel_o && clk_en_o && !low_power_o));

   // R5
   lazy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_DROWSY && !req_s && !start_i) |=> (st_q == SLP_DROWSY));

   // R6
   wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_DROWSY && !req_s && start_i) |=> (st_q == SLP_RECOVER && !low_power_o));

   // R4
   asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_ASLEEP && req_s) |=> low_power_o);

endmodule

// File: rtl/sram_sleep_guard.sv
module sram_sleep_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic in_window_i,
   input  logic start_i,
   input  logic write_i,
   output logic flag_o
);

   logic hit;
   assign hit = in_window_i & (start_i | write_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_o <= 1'b0;
      else if (hit) flag_o <= 1'b1;
   end

   // R7
   window_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_window_i && (start_i || write_i)) |=> flag_o);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o |=> flag_o);

   // R7
   quiet_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_window_i && !flag_o) |=> !flag_o);

endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl #(
   parameter int unsigned STROBES        = 2,
   parameter int unsigned LANES          = 4,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned ENTRY_CYCLES   = 2,
   parameter int unsigned RECOVER_CYCLES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_req,
   input  logic [STROBES-1:0] cmd_strobe,
   input  logic               wr_global,
   input  logic               wr_enable,
   input  logic [LANES-1:0]   wr_lanes,
   output logic               force_desel,
   output logic               core_clk_en,
   output logic               out_disable,
   output logic               low_power,
   output logic               violation
);

   generate
      if (STROBES < 1)        begin : g_bad_strobes $error("STROBES must be at least 1"); end
      if (LANES < 1)          begin : g_bad_lanes   $error("LANES must be at least 1"); end
      if (ENTRY_CYCLES < 1)   begin : g_bad_entry   $error("ENTRY_CYCLES must be at least 1"); end
      if (RECOVER_CYCLES < 1) begin : g_bad_rec     $error("RECOVER_CYCLES must be at least 1"); end
   endgenerate

   logic req_s, start_w, write_w, in_window_w;

   sram_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sleep_req),
      .sync_out (req_s)
   );

   sram_sleep_cmd_dec #(.STROBES(STROBES), .LANES(LANES)) u_dec (
      .cmd_strobe (cmd_strobe),
      .wr_global  (wr_global),
      .wr_enable  (wr_enable),
      .wr_lanes   (wr_lanes),
      .start_o    (start_w),
      .write_o    (write_w)
   );

   sram_sleep_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_s         (req_s),
      .start_i       (start_w),
      .force_desel_o (force_desel),
      .clk_en_o      (core_clk_en),
      .out_dis_o     (out_disable),
      .low_power_o   (low_power),
      .in_window_o   (in_window_w)
   );

   sram_sleep_guard u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_window_i (in_window_w),
      .start_i     (start_w),
      .write_i     (write_w),
      .flag_o      (violation)
   );

   // R8
   lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_window_w && !wr_global && !(|cmd_strobe) && !(wr_enable && (|wr_lanes)) && !violation)
      |=> !violation);

   // R6
   desel_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_window_w |-> force_desel);

endmodule

// File: tb/sram_sleep_ctrl_tb_top.sv
module sram_sleep_ctrl_tb_top;

   localparam int NS = 2;
   localparam int NB = 4;
   localparam int CLK_NS = 10;

   // expected vector layout: {force_desel, core_clk_en, out_disable, low_power, violation}
   localparam logic [4:0] E_RUN = 5'b01000;
   localparam logic [4:0] E_WIN = 5'b11000;
   localparam logic [4:0] E_LP  = 5'b10110;

   typedef struct {
      logic [4:0] exp;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0;
   logic [NS-1:0] cmd_strobe = '0;
   logic wr_global = 1'b0;
   logic wr_enable = 1'b0;
   logic [NB-1:0] wr_lanes = '0;
   logic force_desel, core_clk_en, out_disable, low_power, violation;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;
   item_t sb_q[$];

   always #(CLK_NS/2) clk = ~clk;

   sram_sleep_ctrl #(.STROBES(NS), .LANES(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmd_strobe(cmd_strobe),
      .wr_global(wr_global), .wr_enable(wr_enable), .wr_lanes(wr_lanes),
      .force_desel(force_desel), .core_clk_en(core_clk_en), .out_disable(out_disable),
      .low_power(low_power), .violation(violation)
   );

   // monitor: pops one expected item per edge, sampled after the edge settles
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            item_t it;
            logic [4:0] act;
            it  = sb_q.pop_front();
            act = {force_desel, core_clk_en, out_disable, low_power, violation};
            n_checks++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic step(input logic req, input logic [NS-1:0] stb, input logic wg,
                       input logic we, input logic [NB-1:0] lanes,
                       input logic [4:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      sleep_req  = req;
      cmd_strobe = stb;
      wr_global  = wg;
      wr_enable  = we;
      wr_lanes   = lanes;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(input logic req, input logic [4:0] exp, input string tag);
      step(req, '0, 1'b0, 1'b0, '0, exp, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sleep_req = 1'b0; cmd_strobe = '0; wr_global = 1'b0; wr_enable = 1'b0; wr_lanes = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic go_to_sleep();
      idle(1'b1, E_RUN, "R2 sync stage 1");
      idle(1'b1, E_RUN, "R2 sync stage 2");
      idle(1'b1, E_WIN, "R2 entry window first");
      idle(1'b1, E_WIN, "R2 entry window second");
      idle(1'b1, E_LP,  "R3 low power reached");
   endtask

   task automatic release_req();
      idle(1'b0, E_LP, "R5 release sync 1");
      idle(1'b0, E_LP, "R5 release sync 2");
      idle(1'b0, E_LP, "R5 release seen, still low power");
   endtask

   initial begin
      #(CLK_NS * 5000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // scenario 1: clean entry, ignored traffic, lazy exit, recovery
      do_reset();
      idle(1'b0, E_RUN, "R1 reset state");
      go_to_sleep();
      step(1'b1, 2'b11, 1'b1, 1'b1, 4'hF, E_LP, "R4 commands ignored asleep");
      release_req();
      idle(1'b0, E_LP, "R5 no wake without command");
      step(1'b0, '0, 1'b1, 1'b0, '0, E_LP, "R5 write without strobe no wake");
      step(1'b0, 2'b01, 1'b0, 1'b0, '0, E_WIN, "R6 strobe opens recovery");
      idle(1'b0, E_WIN, "R6 recovery second cycle");
      idle(1'b0, E_RUN, "R6 normal operation resumes");
      step(1'b0, 2'b10, 1'b1, 1'b0, '0, E_RUN, "R7 run commands no violation");

      // scenario 2: write in the entry window, lane qualification
      do_reset();
      idle(1'b1, E_RUN, "R2 sync stage 1");
      idle(1'b1, E_RUN, "R2 sync stage 2");
      idle(1'b1, E_WIN, "R2 entry window first");
      step(1'b1, '0, 1'b0, 1'b1, 4'h0, E_WIN, "R8 enable with no lanes is not a write");
      step(1'b1, '0, 1'b0, 1'b1, 4'h4, E_LP | 5'b00001, "R7 lane write in entry window");
      idle(1'b1, E_LP | 5'b00001, "R9 violation sticky");
      do_reset();
      idle(1'b0, E_RUN, "R9 cleared by reset");

      // scenario 3: strobe in the recovery window
      go_to_sleep();
      release_req();
      step(1'b0, 2'b10, 1'b0, 1'b0, '0, E_WIN, "R6 wake on strobe");
      step(1'b0, 2'b10, 1'b0, 1'b0, '0, E_WIN | 5'b00001, "R7 strobe in recovery window suppressed");
      idle(1'b0, E_RUN | 5'b00001, "R9 sticky after recovery");

      // scenario 4: strobe in the first entry cycle
      do_reset();
      idle(1'b1, E_RUN, "R2 sync stage 1");
      idle(1'b1, E_RUN, "R2 sync stage 2");
      idle(1'b1, E_WIN, "R2 entry window first");
      step(1'b1, 2'b01, 1'b0, 1'b0, '0, E_WIN | 5'b00001, "R7 strobe in entry window");

      @(posedge clk);
      #3;
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule